// File: doc/BRIEF.md
# Packed Byte Dot-Product Accumulator

This block is the arithmetic cell of an integer matrix-multiply engine. It accepts two packed vectors of 8-bit values and a vector of 32-bit running sums. For every 32-bit lane it multiplies four neighbouring byte pairs, adds the four products together, and adds that total to the lane's incoming running sum. The updated sums leave the block two clock cycles later.

Two control inputs set how the bytes are read. One applies to operand A and the other to operand B. Each one chooses between two's-complement and unsigned interpretation, independently of the other. A caller feeds one vector set per cycle while `valid_in` is high. It takes each result when `valid_out` is high and usually sends it back as the next running sum. Between results the output register keeps its last value.

Top module: `dpa_unit`

## Requirements
- R1: Lane i uses bytes 4i..4i+3 of `op_a` and of `op_b`, where byte j occupies bits 8j+7:8j (byte 0 in the least significant bits). The lane result is `acc_in` lane i plus the sum of the four products a[4i+k]·b[4i+k].
- R2: When `zext_a` is 0, the bytes of `op_a` are two's-complement values in -128..127. When it is 1, they are unsigned values in 0..255.
- R3: `zext_b` selects between the same two interpretations for `op_b`, independently of `zext_a`. All four combinations give exact products.
- R4: The final 32-bit addition wraps modulo 2^32 and does not saturate.
- R5: `valid_out` is high exactly two rising edges after the edge that sampled `valid_in` high, and low otherwise.
- R6: While `valid_out` is low, `acc_out` keeps the last result. Input data presented with `valid_in` low has no effect on it.
- R7: After a synchronous reset, `valid_out` is 0 and `acc_out` is all zeros.
- R8: The extreme products are exact. Unsigned 255·255 four times gives 260100. Signed -128·-128 four times gives 65536. Signed -128 times unsigned 255 four times gives -130560.
- R9: Lanes are independent. A wrap in one lane does not change any other lane.
- R10: Inputs on consecutive cycles produce results on consecutive cycles, in the same order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_in | input | 1 | Input vectors are valid this cycle |
| zext_a | input | 1 | 1: bytes of op_a are unsigned; 0: signed |
| zext_b | input | 1 | 1: bytes of op_b are unsigned; 0: signed |
| op_a | input | LANES*32 | Packed bytes of operand A, byte 0 in the LSBs |
| op_b | input | LANES*32 | Packed bytes of operand B, byte 0 in the LSBs |
| acc_in | input | LANES*32 | Incoming 32-bit running sum per lane |
| valid_out | output | 1 | acc_out holds a new result |
| acc_out | output | LANES*32 | Updated 32-bit sums per lane |

## Verification
The hardest cases to reach are the corners of the product range. Mixed-sign operands give the most negative sum, the all-ones unsigned operands give the largest, and a lane has to wrap while its neighbours stay quiet.

The bench sweeps every byte value through every byte position under all four extension modes, back to back. Directed vectors then pin the extremes: 0x80 and 0xFF patterns, and a running sum near 2^32 in one lane with zeros next to it. Idle cycles with changing data check that the output holds its value.

// File: rtl/dpa_pkg.sv
package dpa_pkg;
    localparam int BYTE_W   = 8;
    localparam int LANE_W   = 32;
    localparam int GROUP    = 4;   // byte pairs reduced per lane
    localparam int PROD_W   = 18;  // exact for every signedness mix
    localparam int PSUM_W   = 20;  // four products without overflow

    typedef logic signed [PROD_W-1:0] prod_t;
    typedef logic signed [PSUM_W-1:0] psum_t;

    typedef enum logic [1:0] {
        MODE_SS = 2'b00,
        MODE_SU = 2'b01,
        MODE_US = 2'b10,
        MODE_UU = 2'b11
    } ext_mode_e;

    typedef struct packed {
        psum_t             psum;
        logic [LANE_W-1:0] acc;
    } lane_stage_t;

    function automatic logic signed [BYTE_W:0] widen(input logic [BYTE_W-1:0] v,
                                                     input logic zext);
        return zext ? {1'b0, v} : {v[BYTE_W-1], v};
    endfunction

    function automatic prod_t byte_mul(input logic [BYTE_W-1:0] a, input logic za,
                                       input logic [BYTE_W-1:0] b, input logic zb);
        prod_t xa;
        prod_t xb;
        xa = prod_t'(widen(a, za));
        xb = prod_t'(widen(b, zb));
        return xa * xb;
    endfunction
endpackage

// File: rtl/dpa_lane_reduce.sv
module dpa_lane_reduce
    import dpa_pkg::*;
(
    input  logic [GROUP*BYTE_W-1:0] a_bytes,
    input  logic [GROUP*BYTE_W-1:0] b_bytes,
    input  ext_mode_e               mode,
    output psum_t                   psum
);
    prod_t prods [GROUP];

    for (genvar k = 0; k < GROUP; k++) begin : g_mul
        assign prods[k] = byte_mul(a_bytes[k*BYTE_W +: BYTE_W], mode[1],
                                   b_bytes[k*BYTE_W +: BYTE_W], mode[0]);
    end

    always_comb begin
        psum = '0;
        for (int k = 0; k < GROUP; k++) begin
            psum = psum + psum_t'(prods[k]);
        end
    end
endmodule

// File: rtl/dpa_prod_stage.sv
module dpa_prod_stage
    import dpa_pkg::*;
#(
    parameter int LANES = 8,
    localparam int VW = LANES * LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    valid_in,
    input  ext_mode_e               mode,
    input  logic [VW-1:0]           op_a,
    input  logic [VW-1:0]           op_b,
    input  logic [VW-1:0]           acc_in,
    output logic                    s1_valid,
    output lane_stage_t [LANES-1:0] s1_q
);
    psum_t psum_d [LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        dpa_lane_reduce i_reduce (
            .a_bytes (op_a[i*LANE_W +: LANE_W]),
            .b_bytes (op_b[i*LANE_W +: LANE_W]),
            .mode    (mode),
            .psum    (psum_d[i])
        );

        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q[i] <= '0;
            end else if (valid_in) begin
                s1_q[i].psum <= psum_d[i];
                s1_q[i].acc  <= acc_in[i*LANE_W +: LANE_W];
            end
        end

        // R8: the reduced sum stays inside the exact product range
        a_r8_psum_range: assert property (@(posedge clk) disable iff (rst)
            s1_valid |-> (s1_q[i].psum >= -130560 && s1_q[i].psum <= 260100));
    end

    always_ff @(posedge clk) begin
        if (rst) s1_valid <= 1'b0;
        else     s1_valid <= valid_in;
    end

    a_r5_issue: assert property (@(posedge clk) disable iff (rst)
        valid_in |=> s1_valid);
endmodule

// File: rtl/dpa_acc_stage.sv
module dpa_acc_stage
    import dpa_pkg::*;
#(
    parameter int LANES = 8,
    localparam int VW = LANES * LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    s1_valid,
    input  lane_stage_t [LANES-1:0] s1_q,
    output logic                    valid_out,
    output logic [VW-1:0]           acc_out
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic [LANE_W-1:0] ext_sum;
        assign ext_sum = {{(LANE_W-PSUM_W){s1_q[i].psum[PSUM_W-1]}}, s1_q[i].psum};

        always_ff @(posedge clk) begin
            if (rst)           acc_out[i*LANE_W +: LANE_W] <= '0;
            else if (s1_valid) acc_out[i*LANE_W +: LANE_W] <= s1_q[i].acc + ext_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) valid_out <= 1'b0;
        else     valid_out <= s1_valid;
    end

    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> $stable(acc_out));
    a_r5_follow: assert property (@(posedge clk) disable iff (rst)
        s1_valid |=> valid_out);
    a_r5_idle: assert property (@(posedge clk) disable iff (rst)
        !s1_valid |=> !valid_out);
endmodule

// File: rtl/dpa_unit.sv
module dpa_unit
    import dpa_pkg::*;
#(
    parameter int LANES = 8,
    localparam int VW = LANES * LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          valid_in,
    input  logic          zext_a,
    input  logic          zext_b,
    input  logic [VW-1:0] op_a,
    input  logic [VW-1:0] op_b,
    input  logic [VW-1:0] acc_in,
    output logic          valid_out,
    output logic [VW-1:0] acc_out
);
    ext_mode_e               mode;
    logic                    s1_valid;
    lane_stage_t [LANES-1:0] s1_q;

    assign mode = ext_mode_e'({zext_a, zext_b});

    dpa_prod_stage #(.LANES(LANES)) i_prod (
        .clk      (clk),
        .rst      (rst),
        .valid_in (valid_in),
        .mode     (mode),
        .op_a     (op_a),
        .op_b     (op_b),
        .acc_in   (acc_in),
        .s1_valid (s1_valid),
        .s1_q     (s1_q)
    );

    dpa_acc_stage #(.LANES(LANES)) i_acc (
        .clk       (clk),
        .rst       (rst),
        .s1_valid  (s1_valid),
        .s1_q      (s1_q),
        .valid_out (valid_out),
        .acc_out   (acc_out)
    );

    // R7: reset clears the result and its valid flag
    a_r7_reset: assert property (@(posedge clk)
        rst |=> (!valid_out && acc_out == '0));
endmodule

// File: tb/test_dpa_unit.sv
module test_dpa_unit;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 4;
    localparam int VW = LANES * 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          valid_in = 1'b0;
    logic          zext_a = 1'b0;
    logic          zext_b = 1'b0;
    logic [VW-1:0] op_a = '0;
    logic [VW-1:0] op_b = '0;
    logic [VW-1:0] acc_in = '0;
    logic          valid_out;
    logic [VW-1:0] acc_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // expectation pipeline: slot 0 = driven last step, slot 1 = two steps ago
    logic          pv0 = 0, pv1 = 0;
    logic [VW-1:0] pe0 = '0, pe1 = '0, last = '0;
    string         pt0 = "", pt1 = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    dpa_unit #(.LANES(LANES)) i_dpa_unit (
        .clk(clk), .rst(rst), .valid_in(valid_in), .zext_a(zext_a), .zext_b(zext_b),
        .op_a(op_a), .op_b(op_b), .acc_in(acc_in),
        .valid_out(valid_out), .acc_out(acc_out)
    );

    function automatic logic [VW-1:0] model(input logic za, input logic zb,
                                            input logic [VW-1:0] a, input logic [VW-1:0] b,
                                            input logic [VW-1:0] acc);
        logic [VW-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            int s = 0;
            for (int k = 0; k < 4; k++) begin
                int idx = l*4 + k;
                int ea = za ? int'(a[idx*8 +: 8]) : int'($signed(a[idx*8 +: 8]));
                int eb = zb ? int'(b[idx*8 +: 8]) : int'($signed(b[idx*8 +: 8]));
                s += ea * eb;
            end
            r[l*32 +: 32] = acc[l*32 +: 32] + 32'(s);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string tag,
                         input logic [VW-1:0] got, input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic cyc(input logic v, input logic za, input logic zb,
                       input logic [VW-1:0] a, input logic [VW-1:0] b,
                       input logic [VW-1:0] acc, input string tag);
        @(negedge clk);
        check(valid_out === pv1, "R5 valid timing", VW'(valid_out), VW'(pv1));
        if (pv1) begin
            check(acc_out === pe1, pt1, acc_out, pe1);
            last = pe1;
        end else begin
            check(acc_out === last, "R6 hold while idle", acc_out, last);
        end
        pv1 = pv0; pe1 = pe0; pt1 = pt0;
        pv0 = v;   pe0 = model(za, zb, a, b, acc); pt0 = tag;
        valid_in = v; zext_a = za; zext_b = zb;
        op_a = a; op_b = b; acc_in = acc;
    endtask

    task automatic flush();
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b0, '0, '0, '0, "R6 flush");
    endtask

    initial begin
        logic [VW-1:0] a, b, acc;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R7: reset state
        check(valid_out === 1'b0, "R7 reset valid", VW'(valid_out), '0);
        check(acc_out === '0, "R7 reset acc", acc_out, '0);

        // R1 R2 R3 R10: every byte value in every position, all four modes, back to back
        for (int m = 0; m < 4; m++) begin
            for (int ai = 0; ai < 256; ai++) begin
                for (int bj = 0; bj < 8; bj++) begin
                    for (int l = 0; l < LANES; l++) begin
                        for (int k = 0; k < 4; k++) begin
                            a[(l*4+k)*8 +: 8] = 8'(ai + 64*k + 16*l);
                            b[(l*4+k)*8 +: 8] = 8'(bj*37 + 29*k + 83*l + ai*3);
                        end
                        acc[l*32 +: 32] = {8'(ai), 8'(bj), 8'(l*71), 8'(m*53 + ai)};
                    end
                    cyc(1'b1, m[1], m[0], a, b, acc, "R1 R2 R3 R10 sweep");
                end
            end
        end
        flush();

        // R8: extremes
        cyc(1'b1, 1'b1, 1'b1, {VW/8{8'hFF}}, {VW/8{8'hFF}}, '0, "R8 unsigned max");
        cyc(1'b1, 1'b0, 1'b0, {VW/8{8'h80}}, {VW/8{8'h80}}, '0, "R8 signed min squared");
        cyc(1'b1, 1'b0, 1'b1, {VW/8{8'h80}}, {VW/8{8'hFF}}, '0, "R8 mixed most negative");
        cyc(1'b1, 1'b1, 1'b0, {VW/8{8'hFF}}, {VW/8{8'h80}}, '0, "R8 R3 mixed swapped");
        // R4: wrap modulo 2^32
        cyc(1'b1, 1'b0, 1'b0, {VW/8{8'h01}}, {VW/8{8'h01}}, {LANES{32'hFFFF_FFFF}}, "R4 wrap up");
        cyc(1'b1, 1'b0, 1'b0, {VW/8{8'hFF}}, {VW/8{8'h01}}, '0, "R4 wrap down");
        // R9: lane 0 wraps, others zero data
        a = '0; b = '0; acc = {32'd7, 32'd6, 32'd5, 32'hFFFF_FFF0};
        a[31:0] = 32'hFFFF_FFFF; b[31:0] = 32'hFFFF_FFFF;
        cyc(1'b1, 1'b1, 1'b1, a, b, acc, "R9 lane isolation");
        // R5 R6: gapped valids with noisy idle data
        for (int i = 0; i < 20; i++) begin
            logic v = (i % 3 == 0);
            a = {LANES{32'(i * 32'h1357_9BDF)}};
            b = {LANES{32'(i * 32'h2468_ACE1)}};
            acc = {LANES{32'(i * 77)}};
            cyc(v, 1'(i), 1'(i >> 1), a, b, acc, "R5 R6 gapped");
        end
        flush();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule